// File: doc/BRIEF.md
# Nibble-Addressed Control Latch Bus

This block sits at both ends of a narrow parallel control bus. One byte-wide port carries a 4-bit location number in its upper half and a 4-bit value in its lower half. A separate strobe line for each decode group selects which group of locations the access targets. With two strobes and sixteen nibble locations per group, the bus reaches 128 control bits, held in output latches that drive the peripheral loads. The same address and strobe also select one of 128 bits of peripheral input, arranged as nibbles, to return on reads.

A small state machine tracks each access. It has three states. `ST_IDLE` means no strobe is active. `ST_HOLD` means exactly one strobe is active and its group is recorded. `ST_CLASH` means more than one strobe was seen. Its transitions are:
- IDLE→HOLD when exactly one strobe is sampled high.
- IDLE→CLASH when more than one strobe is sampled high.
- HOLD→HOLD while the recorded strobe stays high alone. In this transition the byte and the direction are re-captured.
- HOLD→IDLE when all strobes are sampled low. A pending write is committed on this transition.
- HOLD→CLASH when any other strobe rises. The access is abandoned.
- CLASH→CLASH while any strobe remains high.
- CLASH→IDLE once all strobes are sampled low.

Writes therefore take effect on the release of the strobe. Reads drive data combinationally while the access is held.

Top module: `nib_ctl_bus`

## Requirements
- R1: On `bus_byte`, bits 7..4 are the location number and bits 3..0 are the data nibble.
- R2: A write is an access in which `wr_dir` was 1 in the last cycle its strobe was sampled high. It stores that cycle's data nibble into the addressed latch at the clock edge where all strobes are first sampled low. When a strobe is held for several cycles, only the byte from that last cycle counts.
- R3: `bus_en[g]` selects group g. Location a of group g occupies bits `(g*16+a)*4 +: 4` of both `ctl_latches` and `rd_bufs`, giving 128 bits in total.
- R4: `rd_nib` shows the selected nibble of `rd_bufs` only under all of these conditions: the machine is in HOLD for group g, exactly `bus_en[g]` is high, and `wr_dir` is 0. The location comes from the current `bus_byte[7:4]`. At all other times `rd_nib` is 0.
- R5: The latches change only through a committed write. Read accesses leave them unchanged.
- R6: If more than one strobe is sampled high, `clash_err` is 1 from the next edge until the edge where all strobes are sampled low. No write is committed, even if one strobe was already active when the second one rose.
- R7: Reset (`rst_n` = 0) clears every latch, puts the machine in IDLE, and forces `rd_nib` and `clash_err` to 0.

Port descriptions:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_byte | input | 8 | Location number (upper nibble) and data (lower nibble) |
| bus_en | input | 2 | One strobe per decode group |
| wr_dir | input | 1 | 1 = write, 0 = read |
| rd_bufs | input | 128 | Peripheral input nibbles returned on reads |
| ctl_latches | output | 128 | Stored control nibbles |
| rd_nib | output | 4 | Read data nibble |
| clash_err | output | 1 | More than one strobe active |

## Verification
Several properties are checked by assertions on every cycle:
- entry into and exit from CLASH;
- latches that stay stable whenever no commit occurs, and during a clash;
- latch changes only at an edge where all strobes were low;
- a zero read nibble while no strobe is high.

Other behaviours only the bench's scenarios can show, because each depends on the history of a whole access:
- that the last byte of a long strobe wins;
- that the stored nibble lands in the right group and slot;
- that an access abandoned by a late second strobe writes nothing;
- that the read mux picks the correct nibble.

// File: rtl/nib_bus_pkg.sv
package nib_bus_pkg;
    parameter int NB_GROUPS = 2;
    parameter int NB_ADDR_W = 4;
    parameter int NB_DATA_W = 4;
    localparam int NB_BUS_W = NB_ADDR_W + NB_DATA_W;
    localparam int NB_LOCS  = 1 << NB_ADDR_W;
    localparam int NB_TOTAL = NB_GROUPS * NB_LOCS * NB_DATA_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_CLASH = 2'd2
    } bus_state_t;
endpackage

// File: rtl/nib_bus_fsm.sv
module nib_bus_fsm
    import nib_bus_pkg::*;
#(
    parameter int GROUPS = NB_GROUPS,
    parameter int BUS_W  = NB_BUS_W,
    localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUPS-1:0] bus_en,
    input  logic [BUS_W-1:0]  bus_byte,
    input  logic              wr_dir,
    output bus_state_t        state,
    output logic [GRP_W-1:0]  act_grp,
    output logic [BUS_W-1:0]  wr_byte,
    output logic              wr_stb,
    output logic              rd_act
);
    bus_state_t        nxt;
    logic              hold_wr;
    logic [GRP_W-1:0]  pick;
    logic [GROUPS-1:0] grp_mask;
    int                en_cnt;

    always_comb begin
        pick = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (bus_en[g]) pick = GRP_W'(g);
        end
        en_cnt   = $countones(bus_en);
        grp_mask = GROUPS'(1) << act_grp;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (en_cnt > 1)       nxt = ST_CLASH;
                else if (en_cnt == 1) nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if ((bus_en & ~grp_mask) != '0) nxt = ST_CLASH;
                else if ((bus_en & grp_mask) == '0) nxt = ST_IDLE;
            end
            ST_CLASH: begin
                if (bus_en == '0) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            act_grp <= '0;
            wr_byte <= '0;
            hold_wr <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == ST_HOLD) begin
                wr_byte <= bus_byte;
                hold_wr <= wr_dir;
                if (state == ST_IDLE) act_grp <= pick;
            end
        end
    end

    always_comb begin
        wr_stb = 1'b0;
        rd_act = 1'b0;
        unique case (state)
            ST_HOLD: begin
                wr_stb = (bus_en == '0) && hold_wr;
                rd_act = (bus_en == grp_mask) && !wr_dir;
            end
            ST_IDLE, ST_CLASH: ;
            default: ;
        endcase
    end

    assert_clash_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(bus_en) > 1) |=> (state == ST_CLASH));
    assert_clash_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CLASH) && (bus_en == '0)) |=> (state == ST_IDLE));
    assert_hold_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> ($past(bus_en) != '0) && ($countones($past(bus_en)) == 1));
endmodule

// File: rtl/nib_latch_bank.sv
module nib_latch_bank
    import nib_bus_pkg::*;
#(
    parameter int GROUPS = NB_GROUPS,
    parameter int ADDR_W = NB_ADDR_W,
    parameter int DATA_W = NB_DATA_W,
    localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int LOCS  = 1 << ADDR_W,
    localparam int TOTAL = GROUPS * LOCS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [GRP_W-1:0]  wr_grp,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TOTAL-1:0]  latch_flat
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic grp_hit;
        assign grp_hit = wr_stb && (wr_grp == GRP_W'(g));
        for (genvar a = 0; a < LOCS; a++) begin : g_loc
            logic [DATA_W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                                cell_q <= '0;
                else if (grp_hit && wr_addr == ADDR_W'(a)) cell_q <= wr_data;
            end
            assign latch_flat[(g*LOCS+a)*DATA_W +: DATA_W] = cell_q;
        end
    end

    assert_quiet_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(latch_flat));
endmodule

// File: rtl/nib_rd_mux.sv
module nib_rd_mux
    import nib_bus_pkg::*;
#(
    parameter int GROUPS = NB_GROUPS,
    parameter int ADDR_W = NB_ADDR_W,
    parameter int DATA_W = NB_DATA_W,
    localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int TOTAL = GROUPS * (1 << ADDR_W) * DATA_W
) (
    input  logic              rd_act,
    input  logic [GRP_W-1:0]  rd_grp,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [TOTAL-1:0]  rd_bufs,
    output logic [DATA_W-1:0] rd_nib
);
    logic [GRP_W+ADDR_W-1:0] slot;
    assign slot   = {rd_grp, rd_addr};
    assign rd_nib = rd_act ? rd_bufs[int'(slot)*DATA_W +: DATA_W] : '0;
endmodule

// File: rtl/nib_ctl_bus.sv
module nib_ctl_bus
    import nib_bus_pkg::*;
#(
    parameter int GROUPS = NB_GROUPS,
    parameter int ADDR_W = NB_ADDR_W,
    parameter int DATA_W = NB_DATA_W,
    localparam int BUS_W = ADDR_W + DATA_W,
    localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int TOTAL = GROUPS * (1 << ADDR_W) * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_byte,
    input  logic [GROUPS-1:0] bus_en,
    input  logic              wr_dir,
    input  logic [TOTAL-1:0]  rd_bufs,
    output logic [TOTAL-1:0]  ctl_latches,
    output logic [DATA_W-1:0] rd_nib,
    output logic              clash_err
);
    bus_state_t       state;
    logic [GRP_W-1:0] act_grp;
    logic [BUS_W-1:0] wr_byte;
    logic             wr_stb;
    logic             rd_act;

    nib_bus_fsm #(.GROUPS(GROUPS), .BUS_W(BUS_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_byte(bus_byte),
        .wr_dir(wr_dir), .state(state), .act_grp(act_grp),
        .wr_byte(wr_byte), .wr_stb(wr_stb), .rd_act(rd_act)
    );

    nib_latch_bank #(.GROUPS(GROUPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_grp(act_grp),
        .wr_addr(wr_byte[BUS_W-1:DATA_W]), .wr_data(wr_byte[DATA_W-1:0]),
        .latch_flat(ctl_latches)
    );

    nib_rd_mux #(.GROUPS(GROUPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) mux_i (
        .rd_act(rd_act), .rd_grp(act_grp), .rd_addr(bus_byte[BUS_W-1:DATA_W]),
        .rd_bufs(rd_bufs), .rd_nib(rd_nib)
    );

    assign clash_err = (state == ST_CLASH);

    assert_write_on_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_latches != $past(ctl_latches)) |-> ($past(bus_en) == '0));
    assert_clash_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clash_err |=> $stable(ctl_latches));
    assert_read_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en == '0) |-> (rd_nib == '0));
    assert_write_blocks_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |-> (rd_nib == '0));
endmodule

// File: tb/nib_ctl_bus_tb_top.sv
module nib_ctl_bus_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_byte = '0;
    logic [1:0]   bus_en = '0;
    logic         wr_dir = 1'b0;
    logic [127:0] rd_bufs = '0;
    logic [127:0] ctl_latches;
    logic [3:0]   rd_nib;
    logic         clash_err;

    int errs = 0;
    int checks = 0;

    // behavioural model
    int       mst = 0;       // 0 idle, 1 held, 2 clash
    int       mg = 0;
    int       mb = 0;
    bit       mw = 0;
    bit [3:0] mlat [32];
    bit       done = 0;

    always #10 clk = ~clk;

    nib_ctl_bus dut_i (
        .clk(clk), .rst_n(rst_n), .bus_byte(bus_byte), .bus_en(bus_en),
        .wr_dir(wr_dir), .rd_bufs(rd_bufs), .ctl_latches(ctl_latches),
        .rd_nib(rd_nib), .clash_err(clash_err)
    );

    task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int cnt;
        cnt = int'(bus_en[0]) + int'(bus_en[1]);
        if (!rst_n) begin
            mst = 0;
            for (int i = 0; i < 32; i++) mlat[i] = 4'h0;
        end else begin
            case (mst)
                0: if (cnt > 1) mst = 2;
                   else if (cnt == 1) begin
                       mst = 1; mg = bus_en[1] ? 1 : 0; mb = int'(bus_byte); mw = wr_dir;
                   end
                1: if (bus_en[1-mg]) mst = 2;
                   else if (bus_en[mg]) begin mb = int'(bus_byte); mw = wr_dir; end
                   else begin
                       if (mw) mlat[mg*16 + (mb >> 4)] = 4'(mb & 15);
                       mst = 0;
                   end
                default: if (bus_en == 2'b00) mst = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        logic [127:0] elat;
        logic [3:0]   erd;
        #5;
        if (!done) begin
            for (int i = 0; i < 32; i++) elat[i*4 +: 4] = mlat[i];
            erd = 4'h0;
            if (mst == 1 && bus_en == (2'b01 << mg) && !wr_dir)
                erd = rd_bufs[(mg*16 + int'(bus_byte[7:4]))*4 +: 4];
            chk(ctl_latches == elat, "R2/R3/R5 latches vs model", ctl_latches, elat);
            chk(rd_nib == erd, "R4 read nibble vs model", 128'(rd_nib), 128'(erd));
            chk(clash_err == (mst == 2), "R6 clash flag vs model", 128'(clash_err), 128'(mst == 2));
        end
    end

    task automatic access(input int g, input int a, input int d, input bit wr, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            bus_en = 2'b01 << g; wr_dir = wr; bus_byte = 8'((a << 4) | d);
        end
        @(negedge clk);
        bus_en = 2'b00; wr_dir = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        chk(ctl_latches == '0, "R7 latches clear in reset", ctl_latches, 0);
        chk(rd_nib == 0 && clash_err == 0, "R7 outputs idle in reset", {rd_nib, clash_err}, 0);
        @(negedge clk); rst_n = 1'b1;
        rd_bufs = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

        access(0, 3, 4'hA, 1, 1);
        #5 chk(ctl_latches[12 +: 4] == 4'hA, "R1 R2 group0 loc3", ctl_latches[12 +: 4], 4'hA);
        access(1, 15, 4'h5, 1, 1);
        #5 chk(ctl_latches[124 +: 4] == 4'h5, "R3 group1 loc15", ctl_latches[124 +: 4], 4'h5);
        chk(ctl_latches[60 +: 4] == 4'h0, "R3 group0 loc15 untouched", ctl_latches[60 +: 4], 0);
        // long strobe: only the final byte is kept (R2)
        @(negedge clk); bus_en = 2'b10; wr_dir = 1; bus_byte = 8'h21;
        @(negedge clk); bus_byte = 8'h22;
        @(negedge clk); bus_byte = 8'h27;
        @(negedge clk); bus_en = 0; wr_dir = 0;
        @(negedge clk); #5 chk(ctl_latches[72 +: 4] == 4'h7, "R2 last byte wins", ctl_latches[72 +: 4], 4'h7);
        // read scan, no latch change (R4, R5)
        @(negedge clk); bus_en = 2'b01; bus_byte = 8'h40;
        @(negedge clk); #5 chk(rd_nib == rd_bufs[16 +: 4], "R4 read group0 loc4", rd_nib, rd_bufs[16 +: 4]);
        @(negedge clk); bus_byte = 8'hE0;
        #5 chk(rd_nib == rd_bufs[56 +: 4], "R4 read scan loc14", rd_nib, rd_bufs[56 +: 4]);
        @(negedge clk); bus_en = 0;
        @(negedge clk); #5 chk(ctl_latches[12 +: 4] == 4'hA, "R5 read kept latch", ctl_latches[12 +: 4], 4'hA);
        // late second strobe aborts a write (R6)
        @(negedge clk); bus_en = 2'b01; wr_dir = 1; bus_byte = 8'h3F;
        @(negedge clk); bus_en = 2'b11;
        @(negedge clk); #5 chk(clash_err == 1, "R6 clash raised", clash_err, 1);
        bus_en = 2'b10;
        @(negedge clk); bus_en = 0; wr_dir = 0;
        @(negedge clk); #5 chk(ctl_latches[12 +: 4] == 4'hA && clash_err == 0, "R6 aborted write ignored", ctl_latches[12 +: 4], 4'hA);

        for (int n = 0; n < 400; n++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k == 0) rd_bufs = {$urandom, $urandom, $urandom, $urandom};
            if (k == 1) begin
                @(negedge clk); bus_en = 2'b11; wr_dir = 1; bus_byte = 8'($urandom);
                @(negedge clk); bus_en = 2'($urandom);
                @(negedge clk); bus_en = 0;
            end else begin
                access(int'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                       int'($urandom_range(0, 15)), 1'($urandom), int'($urandom_range(1, 3)));
            end
        end
        repeat (2) @(negedge clk);
        #6 done = 1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule